// File: doc/BRIEF.md
# Banked Maskable Interrupt Controller

The controller gathers 96 level-sensitive interrupt request lines, grouped into three banks of 32, and presents one interrupt line to a processor. Every source has a mask bit. A set mask bit disables the source. Software reaches the masks through a small word-addressed register port with separate write and read strobes. Each bank has three ways to change its masks: a direct mask register, a write-one-to-set alias and a write-one-to-clear alias. A read-only pending register per bank shows the unmasked input levels.

When the controller is idle, it picks the lowest-numbered source that is both requesting and unmasked. It latches that source number and raises the interrupt output. The latched number and the output then stay fixed until software writes the new-agreement bit in the control register. That write releases the current interrupt. One cycle later a fresh arbitration runs, so a handler can read a stable vector even while other inputs change. A second new-agreement write after the handler finishes does no harm.

Register map (word addresses, with b the bank 0..2): 4b is the mask, 4b+1 is mask-set, 4b+2 is mask-clear, 4b+3 is pending, 12 is status and 13 is control. Source N sits in bank N/32 at bit N%32.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, so each mask register reads 0xFFFFFFFF. After reset irq_out is 0 and the status register reads 0.
- R2: Source N is controlled by bit N%32 of bank N/32. The mask register at word 4b reads back 1 for each disabled source. A write to that register replaces the whole bank mask, and writing all ones disables every source of the bank.
- R3: Writing to the mask-clear alias at word 4b+2 clears each mask bit where the written data holds a 1. Bits written as 0 keep their value. The alias reads as 0.
- R4: Writing to the mask-set alias at word 4b+1 sets each mask bit where the written data holds a 1. Bits written as 0 keep their value. The alias reads as 0.
- R5: The status register at word 12 returns the latched source number in bits [6:0] and a 1 in bit 31 while an interrupt is active. All other bits are 0. The whole register reads 0 when no interrupt is active.
- R6: Once a vector is latched, irq_out stays 1 and the status value stays unchanged until a new-agreement write, whatever the inputs or masks do in the meantime.
- R7: Writing data with bit 0 set to the control register at word 13 drives irq_out to 0 on the next cycle. Arbitration then runs again on the cycle after that. Repeated new-agreement writes are harmless, and the control register reads as 0.
- R8: Arbitration selects the lowest-numbered source whose input is 1 and whose mask bit is 0. If no such source exists, irq_out stays 0.
- R9: The pending register at word 4b+3 reads the bank's input levels ANDed with the inverted mask.
- R10: Addresses other than 0..13 read as 0, and writes to them change no state.
- R11: Read data appears on rdata in the cycle after rd_en is sampled high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 96 | Level-sensitive request lines, source N on bit N |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is a latched vector facing a lower-numbered request that arrives afterwards. The lower source only gets through if the vector is wrongly re-arbitrated, and that happens only while a vector is held and a new unmasked request appears without a new-agreement write. After each vector is latched, the bench raises source 0 plus random other lines and confirms that the status register does not move. Random mask changes made through all three register aliases keep the bench's own mask model in step with the design, so the expected lowest source is known after every release.

// File: rtl/bic_pkg.sv
package bic_pkg;
  typedef enum logic [1:0] {
    SUB_MASK = 2'd0,
    SUB_SET  = 2'd1,
    SUB_CLR  = 2'd2,
    SUB_PEND = 2'd3
  } bank_sub_e;

  localparam int NEWAGR_BIT = 0;
  localparam int ACTIVE_BIT = 31;
endpackage

// File: rtl/bic_mask_bank.sv
module bic_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_mask,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (wr_mask) mask_q <= wdata;
    else if (wr_set)  mask_q <= mask_q | wdata;
    else if (wr_clr)  mask_q <= mask_q & ~wdata;
  end
endmodule

// File: rtl/bic_lowest_first.sv
module bic_lowest_first #(
  parameter int N  = 96,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bic_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  output logic [BANK_W-1:0]           rdata,
  output logic                        irq_out
);
  localparam int NUM_SRC  = NUM_BANKS * BANK_W;
  localparam int VEC_W    = $clog2(NUM_SRC);
  localparam int BSEL_W   = ADDR_W - 2;
  localparam int ADDR_ST  = 4 * NUM_BANKS;
  localparam int ADDR_CTL = ADDR_ST + 1;

  logic [BSEL_W-1:0]  bsel;
  bank_sub_e          sub;
  logic [BANK_W-1:0]  bank_mask [NUM_BANKS];
  logic [BANK_W-1:0]  bank_pend [NUM_BANKS];
  logic [NUM_SRC-1:0] mask_all;
  logic [NUM_SRC-1:0] pend_all;
  logic               win_any;
  logic [VEC_W-1:0]   win_idx;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;
  logic               newagr_wr;
  logic [BANK_W-1:0]  rd_next;
  logic [BANK_W-1:0]  rdata_q;

  assign bsel = addr[ADDR_W-1:2];
  assign sub  = bank_sub_e'(addr[1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (bsel == BSEL_W'(b));
    bic_mask_bank #(.W(BANK_W)) u_mask (
      .clk    (clk),
      .rst    (rst),
      .wr_mask(hit && sub == SUB_MASK),
      .wr_set (hit && sub == SUB_SET),
      .wr_clr (hit && sub == SUB_CLR),
      .wdata  (wdata),
      .mask_q (bank_mask[b])
    );
    assign mask_all[b*BANK_W +: BANK_W] = bank_mask[b];
    assign bank_pend[b] = irq_in[b*BANK_W +: BANK_W] & ~bank_mask[b];
  end

  assign pend_all = irq_in & ~mask_all;

  bic_lowest_first #(.N(NUM_SRC), .IW(VEC_W)) u_pick (
    .req(pend_all),
    .any(win_any),
    .idx(win_idx)
  );

  assign newagr_wr = wr_en && (addr == ADDR_W'(ADDR_CTL)) && wdata[NEWAGR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else if (newagr_wr) begin
      irq_q <= 1'b0;
    end else if (!irq_q && win_any) begin
      irq_q <= 1'b1;
      vec_q <= win_idx;
    end
  end

  always_comb begin
    rd_next = '0;
    if (int'(bsel) < NUM_BANKS) begin
      case (sub)
        SUB_MASK: rd_next = bank_mask[bsel];
        SUB_PEND: rd_next = bank_pend[bsel];
        default:  rd_next = '0;
      endcase
    end else if (addr == ADDR_W'(ADDR_ST) && irq_q) begin
      rd_next             = BANK_W'(vec_q);
      rd_next[ACTIVE_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end

  assign rdata   = rdata_q;
  assign irq_out = irq_q;
endmodule

// File: rtl/bic_chk.sv
module bic_chk #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int VEC_W     = 7
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [BANK_W-1:0]           wdata,
  input logic [NUM_BANKS*BANK_W-1:0] irq_in,
  input logic                        irq_out,
  input logic [VEC_W-1:0]            vec_q,
  input logic [NUM_BANKS*BANK_W-1:0] mask_all
);
  localparam int NUM_SRC  = NUM_BANKS * BANK_W;
  localparam int ADDR_CTL = 4 * NUM_BANKS + 1;

  logic newagr;
  assign newagr = wr_en && (addr == ADDR_W'(ADDR_CTL)) && wdata[0];

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !irq_out); // R1

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (int'(vec_q) < NUM_SRC)); // R5

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !newagr) |=> (irq_out && $stable(vec_q))); // R6

  AST_NEWAGR_DROP: assert property (@(posedge clk) disable iff (rst)
    newagr |=> !irq_out); // R7

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> ((($past(irq_in & ~mask_all)) >> vec_q) & NUM_SRC'(1)) != '0); // R8

  AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> ($past(irq_in & ~mask_all) & ((NUM_SRC'(1) << vec_q) - NUM_SRC'(1))) == '0); // R8

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(4*b+1)) |=>
        ((mask_all[b*BANK_W +: BANK_W] & $past(wdata)) == $past(wdata))); // R4
    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(4*b+2)) |=>
        ((mask_all[b*BANK_W +: BANK_W] & $past(wdata)) == '0)); // R3
  end
endmodule

bind banked_irq_ctrl bic_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .ADDR_W   (ADDR_W),
  .VEC_W    (VEC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq_in  (irq_in),
  .irq_out (irq_out),
  .vec_q   (vec_q),
  .mask_all(mask_all)
);

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m [3];

  banked_irq_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int lowest(input logic [95:0] p);
    for (int i = 0; i < 96; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [95:0] mask_vec();
    return {m[2], m[1], m[0]};
  endfunction

  function automatic logic [31:0] exp_status(input int v);
    return (v < 0) ? 32'h0 : (32'h8000_0000 | 32'(v));
  endfunction

  // Release, re-arbitrate, and compare against the model.
  task automatic release_and_check(input string tag);
    logic [31:0] d;
    int v;
    v = lowest(irq_in & ~mask_vec());
    wr(5'd13, 32'h1);
    check({tag, " R7 drop"}, 32'(irq_out), 32'h0);
    tick(1);
    check({tag, " R8 irq"}, 32'(irq_out), (v >= 0) ? 32'h1 : 32'h0);
    rd(5'd12, d);
    check({tag, " R5 R8 status"}, d, exp_status(v));
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < 3; b++) m[b] = '1;
    tick(3);
    rst = 1'b0;
    tick(1);

    check("R1 irq after reset", 32'(irq_out), 32'h0);
    for (int b = 0; b < 3; b++) begin
      rd(5'(4*b), d);
      check("R1 mask reset", d, 32'hFFFF_FFFF);
    end
    rd(5'd12, d);
    check("R1 status reset", d, 32'h0);

    // R10: out-of-range access
    wr(5'd20, 32'h0);
    wr(5'd14, 32'h0);
    rd(5'd20, d);
    check("R10 read zero", d, 32'h0);
    rd(5'd0, d);
    check("R10 write ignored", d, 32'hFFFF_FFFF);

    // R7 / R3 / R4 alias read-back
    rd(5'd13, d);
    check("R7 control reads zero", d, 32'h0);
    rd(5'd1, d);
    check("R4 set alias reads zero", d, 32'h0);
    rd(5'd2, d);
    check("R3 clear alias reads zero", d, 32'h0);

    // R11: rdata holds after a read
    rd(5'd4, d);
    tick(2);
    check("R11 rdata holds", rdata, 32'hFFFF_FFFF);

    // Directed: source 95 only
    @(negedge clk); irq_in = '0; irq_in[95] = 1'b1;
    wr(5'd10, 32'h8000_0000); m[2] &= ~32'h8000_0000;
    tick(2);
    check("R2 source 95 irq", 32'(irq_out), 32'h1);
    rd(5'd12, d);
    check("R2 R5 vector 95", d, 32'h8000_005F);
    rd(5'd11, d);
    check("R9 pending bank2", d, 32'h8000_0000);

    // Directed: source 0 and 95, lowest wins after release
    @(negedge clk); irq_in[0] = 1'b1;
    wr(5'd2, 32'h1); m[0] &= ~32'h1;
    rd(5'd12, d);
    check("R6 hold on 95", d, 32'h8000_005F);
    release_and_check("dir0");

    // R7: second release is harmless and returns the same winner
    release_and_check("dir0 again");

    // Directed: all masked via direct write of ones
    wr(5'd0, 32'hFFFF_FFFF); m[0] = '1;
    wr(5'd9, 32'h8000_0000); m[2] |= 32'h8000_0000;
    release_and_check("all masked");
    rd(5'd0, d);
    check("R2 all ones disables", d, 32'hFFFF_FFFF);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int op, b;
      logic [31:0] r;
      logic [95:0] ni;
      op = int'($urandom % 3);
      b  = int'($urandom % 3);
      r  = $urandom & $urandom;
      ni = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      @(negedge clk); irq_in = ni;
      wr(5'(4*b + op), r);
      case (op)
        0: m[b] = r;
        1: m[b] = m[b] | r;
        default: m[b] = m[b] & ~r;
      endcase
      rd(5'(4*b), d);
      check((op == 0) ? "R2 direct mask" : (op == 1) ? "R4 set alias" : "R3 clear alias", d, m[b]);
      rd(5'(4*b + 3), d);
      check("R9 pending", d, irq_in[b*32 +: 32] & ~m[b]);
      release_and_check("rand");
      if (irq_out) begin
        rd(5'd12, held);
        @(negedge clk); irq_in = {$urandom, $urandom, $urandom}; irq_in[0] = 1'b1;
        wr(5'd0, 32'h0); m[0] = '0;
        tick(2);
        rd(5'd12, d);
        check("R6 vector held", d, held);
        check("R6 irq held", 32'(irq_out), 32'h1);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule